// File: doc/BRIEF.md
# RTC Prescaler with Frequency Output and Supply-Fail Flag

This block turns a 32.768 kHz reference, presented as a one-cycle enable on the system clock, into the one-second tick that advances the timekeeping counters. A 15-bit binary divider counts the enables. When it wraps, the block issues a single-cycle tick. The same divider produces a half-second strobe. On each strobe the block samples the supply comparator level and latches a sticky supply-fail flag.

The frequency output pin carries one of two signals, chosen by a select input. With select 0 it carries the divider's top stage, a 1 Hz square wave whose falling edge coincides with the tick. With select 1 it carries the raw reference level.

When the serial port signals that a write has started, the divider stops. Its upper eight stages, the 128 Hz through 1 Hz stages, are cleared, and the seven fastest stages keep their value. The divider stays frozen, with ticks and strobes suppressed, until the serial port signals that the write has ended.

Top module: `rtc_prescaler`

## Requirements
- R1: After asynchronous reset, the divider count is 0, `sec_tick_o` is 0 and `fail_flag_o` is 0. With `fsel_i`=0, `fout_o` is therefore 0.
- R2: Each clock cycle with `ref_tick_i`=1 advances the count by one, modulo 32768, provided no write is in progress and `wr_start_i` is 0. `sec_tick_o` is high for exactly one cycle, the cycle after the edge at which the count wraps from 32767 to 0.
- R3: With `fsel_i`=0, `fout_o` equals bit 14 of the count. It is low for the first half-second after each tick and falls in the same cycle that `sec_tick_o` rises.
- R4: With `fsel_i`=1, `fout_o` follows `ref_lvl_i` combinationally.
- R5: An edge with `wr_start_i`=1 clears count bits [14:7], keeps bits [6:0], and does not advance the count.
- R6: After `wr_start_i`, the count is frozen and no tick or strobe is produced until the edge at which `wr_end_i`=1 is seen. That edge itself does not count. If `wr_start_i` and `wr_end_i` are both high at the same edge, the start wins.
- R7: The half-second strobe occurs at an advancing edge where count bits [13:0] are all ones. `det_low_i` is sampled only at that edge, and a 1 sets the flag. `det_low_i` has no effect at any other edge.
- R8: The flag stays set until an edge with `flag_clr_i`=1. When a strobe that sets the flag coincides with a clear, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle enable per 32.768 kHz reference period |
| ref_lvl_i | input | 1 | Reference square-wave level, used for the fast output |
| wr_start_i | input | 1 | Pulse: serial write has begun |
| wr_end_i | input | 1 | Pulse: serial enable has returned low |
| fsel_i | input | 1 | Output select: 0 selects 1 Hz, 1 selects the reference |
| det_low_i | input | 1 | Supply comparator: 1 means below threshold |
| flag_clr_i | input | 1 | Pulse: clear the supply-fail flag |
| sec_tick_o | output | 1 | One-second tick, one cycle wide |
| fout_o | output | 1 | Frequency output |
| fail_flag_o | output | 1 | Sticky supply-fail flag |

## Verification
- `sec_tick_o` is due one cycle after the wrapping edge. The flag changes at the edge that sees the strobe or the clear. `fout_o` follows the select combinationally, and the 1 Hz stage changes at the counting edge.
- The bench keeps its own integer count, hold and flag, updated at each rising edge from the inputs applied at the previous falling edge.
- The bench compares all three outputs at every falling edge, before the next inputs are driven, so every due value is checked in exactly the cycle it appears.
- The collision between a strobe and a clear is arranged by waiting until the bench's own count sits one step before a strobe.

// File: rtl/rtc_presc_pkg.sv
package rtc_presc_pkg;
  localparam int unsigned DIV_W  = 15;  // 32768 reference periods per second
  localparam int unsigned KEEP_W = 7;   // stages above 128 Hz survive a write start
endpackage

// File: rtl/rtc_presc_div.sv
module rtc_presc_div #(
  parameter int unsigned DIV_W  = 15,
  parameter int unsigned KEEP_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_tick_i,
  input  logic             wr_start_i,
  input  logic             wr_end_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic             sec_tick_o,
  output logic             half_stb_o
);
  localparam int unsigned CLR_W = DIV_W - KEEP_W;
  localparam int unsigned HALF_W = DIV_W - 1;
  localparam logic [DIV_W-1:0] CNT_MAX = {DIV_W{1'b1}};

  logic             hold_q;
  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;
  logic             adv;

  assign adv = ref_tick_i & ~hold_q & ~wr_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hold_q <= 1'b0;
    else if (wr_start_i) hold_q <= 1'b1;
    else if (wr_end_i)   hold_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (wr_start_i) cnt_q <= {{CLR_W{1'b0}}, cnt_q[KEEP_W-1:0]};
    else if (adv)        cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= adv & (cnt_q == CNT_MAX);
  end

  assign half_stb_o = adv & (&cnt_q[HALF_W-1:0]);
  assign cnt_o      = cnt_q;
  assign sec_tick_o = tick_q;
endmodule

// File: rtl/rtc_fout_sel.sv
module rtc_fout_sel (
  input  logic fsel_i,
  input  logic ref_lvl_i,
  input  logic slow_i,
  output logic fout_o
);
  assign fout_o = fsel_i ? ref_lvl_i : slow_i;
endmodule

// File: rtl/rtc_supply_flag.sv
module rtc_supply_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic det_low_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // a set wins over a simultaneous clear so that no detection is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_q <= 1'b0;
    else if (stb_i && det_low_i) flag_q <= 1'b1;
    else if (clr_i)              flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_presc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_tick_i,
  input  logic ref_lvl_i,
  input  logic wr_start_i,
  input  logic wr_end_i,
  input  logic fsel_i,
  input  logic det_low_i,
  input  logic flag_clr_i,
  output logic sec_tick_o,
  output logic fout_o,
  output logic fail_flag_o
);
  logic [DIV_W-1:0] cnt;
  logic             half_stb;

  rtc_presc_div #(.DIV_W(DIV_W), .KEEP_W(KEEP_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_tick_i (ref_tick_i),
    .wr_start_i (wr_start_i),
    .wr_end_i   (wr_end_i),
    .cnt_o      (cnt),
    .sec_tick_o (sec_tick_o),
    .half_stb_o (half_stb)
  );

  rtc_fout_sel u_fout (
    .fsel_i    (fsel_i),
    .ref_lvl_i (ref_lvl_i),
    .slow_i    (cnt[DIV_W-1]),
    .fout_o    (fout_o)
  );

  rtc_supply_flag u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (half_stb),
    .det_low_i (det_low_i),
    .clr_i     (flag_clr_i),
    .flag_o    (fail_flag_o)
  );
endmodule

// File: rtl/rtc_prescaler_chk.sv
module rtc_prescaler_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_tick_i,
  input logic ref_lvl_i,
  input logic wr_start_i,
  input logic wr_end_i,
  input logic fsel_i,
  input logic det_low_i,
  input logic flag_clr_i,
  input logic sec_tick_o,
  input logic fout_o,
  input logic fail_flag_o
);
  p_tick_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o);

  p_slow_falls_with_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fsel_i && $past(!fsel_i) && $rose(sec_tick_o)) |-> $fell(fout_o));

  p_no_tick_on_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_i |=> !sec_tick_o);

  p_tick_needs_ref_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sec_tick_o) |-> $past(ref_tick_i));

  p_flag_set_needs_det_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_flag_o) |-> $past(det_low_i));

  p_flag_clear_needs_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fail_flag_o) |-> $past(flag_clr_i));
endmodule

bind rtc_prescaler rtc_prescaler_chk u_chk (.*);

// File: tb/rtc_prescaler_tb.sv
module rtc_prescaler_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_tick_i = 1'b0, ref_lvl_i = 1'b0, wr_start_i = 1'b0, wr_end_i = 1'b0;
  logic fsel_i = 1'b0, det_low_i = 1'b0, flag_clr_i = 1'b0;
  logic sec_tick_o, fout_o, fail_flag_o;

  int n_vec = 0;
  int n_bad = 0;
  string phase = "R1";

  int m_cnt = 0;
  int m_hold = 0;
  int m_flag = 0;
  int m_tick = 0;

  always #2 clk_i = ~clk_i;

  rtc_prescaler u_dut (.*);

  // behavioural reference, fed by inputs settled since the previous falling edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_hold = 0; m_flag = 0; m_tick = 0;
    end else begin
      bit adv, stb;
      adv = ref_tick_i && (m_hold == 0) && !wr_start_i;
      stb = adv && ((m_cnt % 16384) == 16383);
      m_tick = (adv && m_cnt == 32767) ? 1 : 0;
      if (wr_start_i) begin
        m_cnt = m_cnt % 128;
        m_hold = 1;
      end else begin
        if (adv) m_cnt = (m_cnt + 1) % 32768;
        if (wr_end_i) m_hold = 0;
      end
      if (stb && det_low_i) m_flag = 1;
      else if (flag_clr_i)  m_flag = 0;
    end
  end

  task automatic cmp();
    int e_fout;
    e_fout = fsel_i ? int'(ref_lvl_i) : ((m_cnt >= 16384) ? 1 : 0);
    n_vec++;
    if (int'(sec_tick_o) != m_tick) begin
      n_bad++;
      $display("FAIL %s/R2 tick: got %0d exp %0d", phase, sec_tick_o, m_tick);
    end
    if (int'(fout_o) != e_fout) begin
      n_bad++;
      $display("FAIL %s/%s fout: got %0d exp %0d", phase, fsel_i ? "R4" : "R3", fout_o, e_fout);
    end
    if (int'(fail_flag_o) != m_flag) begin
      n_bad++;
      $display("FAIL %s/R8 flag: got %0d exp %0d", phase, fail_flag_o, m_flag);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      cmp();
      ref_lvl_i = ~ref_lvl_i;
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    cyc(1);
    s = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    phase = "R1";
    cyc(2);

    phase = "R2";
    ref_tick_i = 1'b1;
    cyc(33000);

    phase = "R4";
    fsel_i = 1'b1;
    cyc(200);
    fsel_i = 1'b0;

    phase = "R5";
    cyc(77);
    pulse(wr_start_i);
    phase = "R6";
    cyc(300);
    pulse(wr_end_i);
    phase = "R5";
    cyc(33000);

    phase = "R6";
    wr_start_i = 1'b1; wr_end_i = 1'b1;
    cyc(1);
    wr_start_i = 1'b0; wr_end_i = 1'b0;
    cyc(50);
    pulse(wr_end_i);
    cyc(40);

    phase = "R7";
    for (int k = 0; k < 40; k++) begin
      det_low_i = ((m_cnt % 16384) != 16383) && (k % 3 == 0);
      cyc(1);
    end
    det_low_i = 1'b0;
    cyc(20);
    det_low_i = 1'b1;
    cyc(17000);
    det_low_i = 1'b0;

    phase = "R8";
    cyc(100);
    pulse(flag_clr_i);
    cyc(10);
    while ((m_cnt % 16384) != 16383) cyc(1);
    det_low_i = 1'b1; flag_clr_i = 1'b1;
    cyc(1);
    det_low_i = 1'b0; flag_clr_i = 1'b0;
    cyc(20);
    pulse(flag_clr_i);

    phase = "R2";
    for (int k = 0; k < 40000; k++) begin
      ref_tick_i = ($urandom_range(1, 0) == 1);
      det_low_i  = ($urandom_range(7, 0) == 0);
      fsel_i     = (k > 39000);
      cyc(1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog R2: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule